// File: doc/BRIEF.md
# Reservation station with broadcast wakeup

This block is a small pool of issue-queue slots that sits between an in-order dispatch stage and a single execution port. Each slot holds one decoded operation: an opcode, a destination tag, a port-occupancy latency and two source operands. A source operand is either a value already known at dispatch or the tag of the in-flight producer that will create it. Every cycle, each occupied slot compares its outstanding tags against the one result broadcast bus. On a match it keeps the broadcast value in place of the tag.

A slot becomes eligible once both of its operands hold values. A selector then hands eligible slots to the execution port one at a time. When several are eligible it picks the one dispatched earliest. Slots are written in program order but leave in readiness order, so a younger independent operation can overtake an older one that is still waiting. An operation that occupies the port for several cycles blocks all other issue for that time. A flush input empties the pool in one cycle.

The rename logic, register file and execution units sit outside this block. Only the dispatch, broadcast and issue interfaces are modelled.

Top module: `wakeup_issue_queue`

## Requirements
- R1: During reset, and in the cycle after `flush` is high, no slot is occupied: `disp_ready` is 1, `iss_valid` is 0, and later broadcasts cause no issue. A dispatch presented in the same cycle as `flush` is dropped.
- R2: `disp_ready` is 0 exactly when all `NUM_ENTRIES` slots are occupied. A dispatch with `disp_valid`=1 while `disp_ready`=0 is dropped and never issues.
- R3: A source operand with its ready flag at 1 carries a value. One with the flag at 0 waits on its tag. An operation dispatched with both operands ready can issue in the cycle after its dispatch edge, and it issues with those values.
- R4: A broadcast with `bc_valid`=1 whose `bc_tag` equals a waiting operand's tag puts `bc_val` into that operand at that clock edge. A broadcast with any other tag leaves the operand waiting. A slot woken at the end of cycle N issues no earlier than cycle N+1.
- R5: An operand dispatched as waiting on a tag that is broadcast in the same cycle takes `bc_val` at the dispatch edge. The wakeup is not lost.
- R6: A ready slot issues even while an older slot is still waiting on an operand.
- R7: When several slots are ready in the same cycle, the one dispatched earliest issues first, whatever the slot positions.
- R8: At most one slot issues per cycle. `iss_op`, `iss_dst`, `iss_lat`, `iss_a` and `iss_b` carry the issuing slot's opcode, destination tag, latency field, first operand and second operand.
- R9: An operation with latency field L occupies the port for L+1 cycles. No issue happens in the L cycles that follow its issue cycle.
- R10: A slot is released at the edge that ends its issue cycle, so `disp_ready` returns to 1 in the following cycle when the pool was full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties every slot at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least one slot is free |
| disp_op | input | OP_W | Opcode of the dispatched operation |
| disp_dst | input | TAG_W | Destination tag |
| disp_lat | input | LAT_W | Extra port-occupancy cycles |
| disp_a_rdy | input | 1 | First operand is a value |
| disp_a_tag | input | TAG_W | Producer tag of the first operand |
| disp_a_val | input | DATA_W | Value of the first operand |
| disp_b_rdy | input | 1 | Second operand is a value |
| disp_b_tag | input | TAG_W | Producer tag of the second operand |
| disp_b_val | input | DATA_W | Value of the second operand |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | An operation issues this cycle |
| iss_op | output | OP_W | Opcode of the issuing operation |
| iss_dst | output | TAG_W | Destination tag of the issuing operation |
| iss_lat | output | LAT_W | Latency field of the issuing operation |
| iss_a | output | DATA_W | First operand value |
| iss_b | output | DATA_W | Second operand value |

## Verification
Wakeup is swept over every tag value against one waiting slot. Only the matching tag may release it, and only in the cycle after the broadcast, which separates a correct comparator from one that ignores the tag or wakes combinationally. A sequence that frees a low slot and refills it with a younger operation makes age order differ from slot order, so oldest-first selection can be told apart from a lowest-index priority encoder. The latency field is swept from 0 to 3 with a ready operation queued behind, which measures the exact hold-off length. Flush and full-pool dispatches are followed by broadcasts of the relevant tags, so an operation that was dropped incorrectly, or kept when it should have been dropped, shows up at the issue port.

// File: rtl/wiq_pkg.sv
package wiq_pkg;

   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_RDY   = 2'd2
   } slot_state_e;

   localparam int unsigned MAX_SLOTS = 32;

endpackage

// File: rtl/wiq_operand.sv
module wiq_operand #(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   parameter bit          BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ld_rdy,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_val,
   input  logic              watch,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              rdy,
   output logic [DATA_W-1:0] val
);

   logic [TAG_W-1:0] tag_q;
   logic             snoop_hit;
   logic             load_hit;

   assign snoop_hit = watch && !rdy && bc_valid && (bc_tag == tag_q);

   generate
      if (BYPASS) begin : g_bypass
         assign load_hit = bc_valid && (bc_tag == ld_tag);
      end else begin : g_no_bypass
         assign load_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy   <= 1'b0;
         tag_q <= '0;
         val   <= '0;
      end else if (load) begin
         tag_q <= ld_tag;
         if (ld_rdy) begin
            rdy <= 1'b1;
            val <= ld_val;
         end else if (load_hit) begin
            rdy <= 1'b1;
            val <= bc_val;
         end else begin
            rdy <= 1'b0;
         end
      end else if (snoop_hit) begin
         rdy <= 1'b1;
         val <= bc_val;
      end
   end

   AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (watch && !rdy && !load && bc_valid && bc_tag == tag_q)
      |=> (rdy && val == $past(bc_val))); // R4

   generate
      if (BYPASS) begin : g_bypass_chk
         AST_LOAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
            (load && !ld_rdy && bc_valid && bc_tag == ld_tag)
            |=> (rdy && val == $past(bc_val))); // R5
      end
   endgenerate

endmodule

// File: rtl/wiq_entry.sv
module wiq_entry
   import wiq_pkg::*;
#(
   parameter int unsigned OP_W   = 4,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LAT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc,
   input  logic              release_i,
   input  logic [OP_W-1:0]   d_op,
   input  logic [TAG_W-1:0]  d_dst,
   input  logic [LAT_W-1:0]  d_lat,
   input  logic              d_a_rdy,
   input  logic [TAG_W-1:0]  d_a_tag,
   input  logic [DATA_W-1:0] d_a_val,
   input  logic              d_b_rdy,
   input  logic [TAG_W-1:0]  d_b_tag,
   input  logic [DATA_W-1:0] d_b_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              occupied,
   output slot_state_e       state,
   output logic [OP_W-1:0]   op,
   output logic [TAG_W-1:0]  dst,
   output logic [LAT_W-1:0]  lat,
   output logic [DATA_W-1:0] a_val,
   output logic [DATA_W-1:0] b_val
);

   logic a_rdy;
   logic b_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occupied <= 1'b0;
      end else if (flush) begin
         occupied <= 1'b0;
      end else if (alloc) begin
         occupied <= 1'b1;
      end else if (release_i) begin
         occupied <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op  <= '0;
         dst <= '0;
         lat <= '0;
      end else if (alloc) begin
         op  <= d_op;
         dst <= d_dst;
         lat <= d_lat;
      end
   end

   wiq_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BYPASS(1'b1)) i_src_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (alloc),
      .ld_rdy   (d_a_rdy),
      .ld_tag   (d_a_tag),
      .ld_val   (d_a_val),
      .watch    (occupied),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .rdy      (a_rdy),
      .val      (a_val)
   );

   wiq_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BYPASS(1'b1)) i_src_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (alloc),
      .ld_rdy   (d_b_rdy),
      .ld_tag   (d_b_tag),
      .ld_val   (d_b_val),
      .watch    (occupied),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_val   (bc_val),
      .rdy      (b_rdy),
      .val      (b_val)
   );

   always_comb begin
      if (!occupied) begin
         state = SLOT_EMPTY;
      end else if (a_rdy && b_rdy) begin
         state = SLOT_RDY;
      end else begin
         state = SLOT_WAIT;
      end
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !occupied); // R1

   AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |-> (state == SLOT_RDY)); // R3

endmodule

// File: rtl/wiq_age_pick.sv
module wiq_age_pick #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic [N-1:0] occ,
   input  logic [N-1:0] req,
   input  logic [N-1:0] alloc,
   output logic [N-1:0] grant,
   output logic [N-1:0] free_oh,
   output logic         any_free
);

   // older[j][i] = 1 means slot j was dispatched before slot i
   logic [N-1:0] older [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            older[i] <= '0;
         end
      end else begin
         for (int k = 0; k < N; k++) begin
            if (alloc[k]) begin
               for (int j = 0; j < N; j++) begin
                  older[j][k] <= (j != k) && occ[j];
               end
               older[k] <= '0;
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < N; j++) begin
            if (req[j] && older[j][i]) begin
               blocked = 1'b1;
            end
         end
         grant[i] = enable && req[i] && !blocked;
      end
   end

   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < N; i++) begin
         if (!occ[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign any_free = ~&occ;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8

endmodule

// File: rtl/wiq_port_timer.sv
module wiq_port_timer #(
   parameter int unsigned LAT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [LAT_W-1:0] lat,
   output logic             idle
);

   logic [LAT_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (fire) begin
         hold_q <= lat;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - LAT_W'(1);
      end
   end

   assign idle = (hold_q == '0);

   AST_PORT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && lat != '0) |=> !fire); // R9

endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
   import wiq_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned OP_W        = 4,
   parameter int unsigned TAG_W       = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned LAT_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              disp_valid,
   output logic              disp_ready,
   input  logic [OP_W-1:0]   disp_op,
   input  logic [TAG_W-1:0]  disp_dst,
   input  logic [LAT_W-1:0]  disp_lat,
   input  logic              disp_a_rdy,
   input  logic [TAG_W-1:0]  disp_a_tag,
   input  logic [DATA_W-1:0] disp_a_val,
   input  logic              disp_b_rdy,
   input  logic [TAG_W-1:0]  disp_b_tag,
   input  logic [DATA_W-1:0] disp_b_val,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_val,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [TAG_W-1:0]  iss_dst,
   output logic [LAT_W-1:0]  iss_lat,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);

   localparam int unsigned N = NUM_ENTRIES;

   generate
      if (N < 2 || N > MAX_SLOTS) begin : g_bad_depth
         $error("NUM_ENTRIES must lie between 2 and MAX_SLOTS");
      end
      if (TAG_W < 1 || DATA_W < 1 || OP_W < 1 || LAT_W < 1) begin : g_bad_width
         $error("all field widths must be at least one bit");
      end
   endgenerate

   logic [N-1:0]      occ;
   logic [N-1:0]      req;
   logic [N-1:0]      grant;
   logic [N-1:0]      free_oh;
   logic [N-1:0]      alloc;
   logic              any_free;
   logic              port_idle;
   logic              disp_fire;
   slot_state_e       e_state [N];
   logic [OP_W-1:0]   e_op    [N];
   logic [TAG_W-1:0]  e_dst   [N];
   logic [LAT_W-1:0]  e_lat   [N];
   logic [DATA_W-1:0] e_a     [N];
   logic [DATA_W-1:0] e_b     [N];

   assign disp_ready = any_free;
   assign disp_fire  = disp_valid && any_free && !flush;
   assign alloc      = disp_fire ? free_oh : '0;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_slot
         wiq_entry #(
            .OP_W   (OP_W),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W),
            .LAT_W  (LAT_W)
         ) i_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc     (alloc[g]),
            .release_i (grant[g]),
            .d_op      (disp_op),
            .d_dst     (disp_dst),
            .d_lat     (disp_lat),
            .d_a_rdy   (disp_a_rdy),
            .d_a_tag   (disp_a_tag),
            .d_a_val   (disp_a_val),
            .d_b_rdy   (disp_b_rdy),
            .d_b_tag   (disp_b_tag),
            .d_b_val   (disp_b_val),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_val    (bc_val),
            .occupied  (occ[g]),
            .state     (e_state[g]),
            .op        (e_op[g]),
            .dst       (e_dst[g]),
            .lat       (e_lat[g]),
            .a_val     (e_a[g]),
            .b_val     (e_b[g])
         );
         assign req[g] = (e_state[g] == SLOT_RDY);
      end
   endgenerate

   wiq_age_pick #(.N(N)) i_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (port_idle),
      .occ      (occ),
      .req      (req),
      .alloc    (alloc),
      .grant    (grant),
      .free_oh  (free_oh),
      .any_free (any_free)
   );

   always_comb begin
      iss_op  = '0;
      iss_dst = '0;
      iss_lat = '0;
      iss_a   = '0;
      iss_b   = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) begin
            iss_op  = iss_op  | e_op[i];
            iss_dst = iss_dst | e_dst[i];
            iss_lat = iss_lat | e_lat[i];
            iss_a   = iss_a   | e_a[i];
            iss_b   = iss_b   | e_b[i];
         end
      end
   end

   assign iss_valid = |grant;

   wiq_port_timer #(.LAT_W(LAT_W)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (iss_valid),
      .lat   (iss_lat),
      .idle  (port_idle)
   );

   AST_OCC_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready && !flush && !iss_valid)
      |=> ($countones(occ) == $past($countones(occ)) + 1)); // R2

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready && !iss_valid && !flush)
      |=> $stable(occ)); // R2

endmodule

// File: tb/test_wakeup_issue_queue.sv
module test_wakeup_issue_queue;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush;
   logic        disp_valid;
   logic        disp_ready;
   logic [3:0]  disp_op;
   logic [3:0]  disp_dst;
   logic [1:0]  disp_lat;
   logic        disp_a_rdy;
   logic [3:0]  disp_a_tag;
   logic [15:0] disp_a_val;
   logic        disp_b_rdy;
   logic [3:0]  disp_b_tag;
   logic [15:0] disp_b_val;
   logic        bc_valid;
   logic [3:0]  bc_tag;
   logic [15:0] bc_val;
   logic        iss_valid;
   logic [3:0]  iss_op;
   logic [3:0]  iss_dst;
   logic [1:0]  iss_lat;
   logic [15:0] iss_a;
   logic [15:0] iss_b;

   int vectors = 0;
   int errors  = 0;

   always #2.5 clk = ~clk;

   wakeup_issue_queue i_wakeup_issue_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_op(disp_op), .disp_dst(disp_dst), .disp_lat(disp_lat),
      .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
      .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_lat(iss_lat), .iss_a(iss_a), .iss_b(iss_b)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [3:0] op, input logic [3:0] dst, input logic [1:0] lat,
                      input logic ar, input logic [3:0] at, input logic [15:0] av,
                      input logic br, input logic [3:0] bt, input logic [15:0] bv);
      disp_valid = 1'b1;
      disp_op = op; disp_dst = dst; disp_lat = lat;
      disp_a_rdy = ar; disp_a_tag = at; disp_a_val = av;
      disp_b_rdy = br; disp_b_tag = bt; disp_b_val = bv;
      cyc();
      disp_valid = 1'b0;
   endtask

   task automatic bcast(input logic [3:0] tag, input logic [15:0] val);
      bc_valid = 1'b1; bc_tag = tag; bc_val = val;
      cyc();
      bc_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; disp_valid = 1'b0;
      disp_op = '0; disp_dst = '0; disp_lat = '0;
      disp_a_rdy = 1'b0; disp_a_tag = '0; disp_a_val = '0;
      disp_b_rdy = 1'b0; disp_b_tag = '0; disp_b_val = '0;
      bc_valid = 1'b0; bc_tag = '0; bc_val = '0;
      repeat (3) cyc();
      chk("R1 reset disp_ready", 32'(disp_ready), 1);
      chk("R1 reset iss_valid", 32'(iss_valid), 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 idle iss_valid", 32'(iss_valid), 0);

      // R3 / R8: fully ready dispatch issues next cycle with its fields
      put(4'h5, 4'h3, 2'd0, 1'b1, 4'h0, 16'd100, 1'b1, 4'h0, 16'd200);
      chk("R3 ready issue", 32'(iss_valid), 1);
      chk("R3 value a", 32'(iss_a), 100);
      chk("R3 value b", 32'(iss_b), 200);
      chk("R8 dst", 32'(iss_dst), 3);
      chk("R8 op", 32'(iss_op), 5);
      cyc();
      chk("R10 slot released", 32'(iss_valid), 0);

      // R4: tag sweep, only tag 5 wakes
      put(4'h1, 4'h6, 2'd0, 1'b0, 4'h5, 16'd0, 1'b1, 4'h0, 16'd7);
      chk("R4 waiting no issue", 32'(iss_valid), 0);
      for (int t = 0; t < 16; t++) begin
         if (t != 5) begin
            bcast(4'(t), 16'd999);
            chk("R4 nonmatching tag", 32'(iss_valid), 0);
         end
      end
      bc_valid = 1'b1; bc_tag = 4'h5; bc_val = 16'h1234;
      #0;
      chk("R4 no same-cycle issue", 32'(iss_valid), 0);
      cyc();
      bc_valid = 1'b0;
      chk("R4 issue next cycle", 32'(iss_valid), 1);
      chk("R4 captured value", 32'(iss_a), 32'h1234);
      chk("R4 kept b", 32'(iss_b), 7);
      cyc();

      // R5: dispatch-time bypass on both operands
      bc_valid = 1'b1; bc_tag = 4'h9; bc_val = 16'd55;
      put(4'h2, 4'h7, 2'd0, 1'b0, 4'h9, 16'd0, 1'b0, 4'h9, 16'd0);
      bc_valid = 1'b0;
      chk("R5 bypass issue", 32'(iss_valid), 1);
      chk("R5 bypass a", 32'(iss_a), 55);
      chk("R5 bypass b", 32'(iss_b), 55);
      cyc();

      // R6: younger ready overtakes older waiting
      put(4'h3, 4'ha, 2'd0, 1'b0, 4'h2, 16'd0, 1'b1, 4'h0, 16'd1);
      put(4'h4, 4'hb, 2'd0, 1'b1, 4'h0, 16'd8, 1'b1, 4'h0, 16'd9);
      chk("R6 younger issues", 32'(iss_valid), 1);
      chk("R6 younger dst", 32'(iss_dst), 32'hb);
      cyc();
      chk("R6 older still waits", 32'(iss_valid), 0);
      bcast(4'h2, 16'd77);
      chk("R6 older dst", 32'(iss_dst), 32'ha);
      chk("R6 older value", 32'(iss_a), 77);
      cyc();

      // R7 / R2 / R10: age order differs from slot order
      put(4'h1, 4'h0, 2'd0, 1'b0, 4'h6, 16'd0, 1'b1, 4'h0, 16'd1); // slot0
      put(4'h1, 4'h1, 2'd0, 1'b0, 4'h4, 16'd0, 1'b1, 4'h0, 16'd1); // slot1
      put(4'h1, 4'h2, 2'd0, 1'b0, 4'h4, 16'd0, 1'b1, 4'h0, 16'd1); // slot2
      bcast(4'h6, 16'd3);
      chk("R7 first wake dst", 32'(iss_dst), 0);
      cyc();
      put(4'h1, 4'h3, 2'd0, 1'b0, 4'h4, 16'd0, 1'b1, 4'h0, 16'd1); // slot0, younger
      put(4'h1, 4'h4, 2'd0, 1'b0, 4'h4, 16'd0, 1'b1, 4'h0, 16'd1); // slot3
      chk("R2 full", 32'(disp_ready), 0);
      put(4'h1, 4'hf, 2'd0, 1'b1, 4'h0, 16'd1, 1'b1, 4'h0, 16'd1); // dropped
      chk("R2 dropped no issue", 32'(iss_valid), 0);
      bcast(4'h4, 16'h44);
      chk("R7 oldest first", 32'(iss_dst), 1);
      chk("R7 value", 32'(iss_a), 32'h44);
      chk("R10 still full", 32'(disp_ready), 0);
      cyc();
      chk("R7 second", 32'(iss_dst), 2);
      chk("R10 freed", 32'(disp_ready), 1);
      cyc();
      chk("R7 third younger low slot", 32'(iss_dst), 3);
      cyc();
      chk("R7 fourth", 32'(iss_dst), 4);
      cyc();
      chk("R2 dropped never issues", 32'(iss_valid), 0);

      // R9: latency sweep
      for (int l = 0; l < 4; l++) begin
         put(4'h6, 4'h8, 2'(l), 1'b1, 4'h0, 16'd1, 1'b1, 4'h0, 16'd2);
         chk("R9 long op issues", 32'(iss_dst), 8);
         chk("R8 lat field", 32'(iss_lat), 32'(l));
         put(4'h7, 4'h9, 2'd0, 1'b1, 4'h0, 16'd3, 1'b1, 4'h0, 16'd4);
         for (int k = 1; k <= l + 1; k++) begin
            if (k <= l) begin
               chk("R9 port busy", 32'(iss_valid), 0);
               cyc();
            end else begin
               chk("R9 follower issues", 32'(iss_valid), 1);
               chk("R9 follower dst", 32'(iss_dst), 9);
            end
         end
         cyc();
      end

      // R1: flush drops entries and a same-cycle dispatch
      put(4'h1, 4'hc, 2'd0, 1'b0, 4'h7, 16'd0, 1'b1, 4'h0, 16'd1);
      put(4'h1, 4'hd, 2'd0, 1'b0, 4'h8, 16'd0, 1'b1, 4'h0, 16'd1);
      flush = 1'b1;
      put(4'h1, 4'he, 2'd0, 1'b1, 4'h0, 16'd1, 1'b1, 4'h0, 16'd1);
      flush = 1'b0;
      chk("R1 flush ready", 32'(disp_ready), 1);
      chk("R1 flush no issue", 32'(iss_valid), 0);
      bcast(4'h7, 16'd1);
      chk("R1 flushed tag7", 32'(iss_valid), 0);
      bcast(4'h8, 16'd1);
      chk("R1 flushed tag8", 32'(iss_valid), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule